// File: doc/BRIEF.md
# Element-Indexed Vector Register File

This block holds 32 vector registers of 128 bits each and lets a datapath reach them by element number instead of by bit position. Each access gives a base register, an element index, an element width and a group multiplier. The block works out which physical register and which byte lanes hold that element. Writes change only those byte lanes. Reads return the element right-aligned and zero-extended.

When the multiplier is greater than one, a group spans several consecutive registers. When the multiplier is fractional, the group occupies only the low part of one register. A separate mask port returns one bit per element straight from a chosen register, so a mask built at one element width can gate work at any other width. Two flags report problems: one for an index outside the group, and one for a base register that cannot start a group. Either flag blocks the write and forces the read result to zero.

Top module: `elem_vrf`

## Requirements
- R1: Width codes are 0=8, 1=16, 2=32 and 3=64 bits. With multiplier code 000 (one register), element i of width W bytes occupies bytes i*W to i*W+W-1 of the base register, counted from the least significant byte. A read returns the element in the low bits with zeros above.
- R2: Multiplier codes 001, 010 and 011 select groups of 2, 4 and 8 registers. The group fills the base register completely, then continues in base+1, base+2 and so on. For example, 32-bit element 5 of the group at base 2 is element 1 of register 3.
- R3: Multiplier codes 111, 110 and 101 mean 1/2, 1/4 and 1/8. The group then holds (multiplier x 16 bytes) / W elements, all in the low bytes of the base register. A count below one means the group has no elements.
- R4: The mask output is bit i of the register selected on the mask port, where i is the mask index. The result does not depend on any element width or multiplier.
- R5: The out-of-range flag of a port is 1 exactly when the index is at or beyond the group's element count. Such a write changes no storage, and such a read returns zero.
- R6: The illegal-group flag of a port is 1 when multiplier code 100 is given (this code is reserved and its element count is zero). It is also 1 when the multiplier is 2, 4 or 8 and the base is not a multiple of it. Such a write changes no storage, and such a read returns zero.
- R7: A legal write changes only the bytes of the addressed element. All other bytes of every register keep their values.
- R8: Writes take effect on the rising clock edge. A read of the element being written in the same cycle returns the old value, and the new value appears from the next cycle on.
- R9: A synchronous active-high reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrBase | input | 5 | Write base register |
| wrIdx | input | 8 | Write element index |
| wrSew | input | 2 | Write element width code |
| wrLmul | input | 3 | Write multiplier code |
| wrData | input | 64 | Write element value (low bits used) |
| wrOutOfRange | output | 1 | Write index beyond group |
| wrIllegalGroup | output | 1 | Write group illegal |
| rdBase | input | 5 | Read base register |
| rdIdx | input | 8 | Read element index |
| rdSew | input | 2 | Read element width code |
| rdLmul | input | 3 | Read multiplier code |
| rdData | output | 64 | Read element, zero-extended |
| rdOutOfRange | output | 1 | Read index beyond group |
| rdIllegalGroup | output | 1 | Read group illegal |
| maskReg | input | 5 | Mask source register |
| maskIdx | input | 7 | Mask element index |
| maskBit | output | 1 | Mask bit for that element |

## Verification
The bench builds the block with its defaults: 32 registers of 128 bits. With these values every multiplier code reaches a register boundary. A group of eight 8-bit elements reaches index 127, and the 1/8 multiplier with 64-bit elements gives an empty group. Random traffic writes at one width and reads back at another, which exposes any lane-placement error. A flat byte-array model serves as the reference. Directed cases cover the boundaries between group members, the edge of a fractional group, misaligned bases, the reserved multiplier code and a write and read of the same element in one cycle.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

  // Element width codes
  typedef enum logic [1:0] {
    SEW_B8  = 2'd0,
    SEW_B16 = 2'd1,
    SEW_B32 = 2'd2,
    SEW_B64 = 2'd3
  } sew_e;

  // Group multiplier codes (signed log2, 100 reserved)
  localparam logic [2:0] LMUL_X1    = 3'b000;
  localparam logic [2:0] LMUL_X2    = 3'b001;
  localparam logic [2:0] LMUL_X4    = 3'b010;
  localparam logic [2:0] LMUL_X8    = 3'b011;
  localparam logic [2:0] LMUL_RSVD  = 3'b100;
  localparam logic [2:0] LMUL_F8    = 3'b101;
  localparam logic [2:0] LMUL_F4    = 3'b110;
  localparam logic [2:0] LMUL_F2    = 3'b111;

  localparam int ELEN = 64;

endpackage

// File: rtl/vrf_elem_map.sv
module vrf_elem_map
  import vrf_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int VLEN_BYTES = 16,
  parameter int IDX_W      = 8,
  parameter int REG_W      = $clog2(NUM_REGS),
  parameter int OFF_W      = $clog2(VLEN_BYTES)
) (
  input  logic [REG_W-1:0]      base,
  input  logic [IDX_W-1:0]      idx,
  input  sew_e                  sew,
  input  logic [2:0]            lmul,
  output logic [REG_W-1:0]      physReg,
  output logic [OFF_W-1:0]      byteOff,
  output logic [VLEN_BYTES-1:0] byteEn,
  output logic                  outOfRange,
  output logic                  illegalGroup
);

  localparam int CNT_W = IDX_W + 1;
  localparam int LIN_W = IDX_W + 3;

  logic [CNT_W-1:0]      perReg;
  logic [CNT_W-1:0]      elemCount;
  logic [LIN_W-1:0]      byteLinear;
  logic [VLEN_BYTES-1:0] elemMask;

  // Element count of the group
  always_comb begin
    perReg = CNT_W'(VLEN_BYTES) >> sew;
    unique case (lmul)
      LMUL_X1: elemCount = perReg;
      LMUL_X2: elemCount = perReg << 1;
      LMUL_X4: elemCount = perReg << 2;
      LMUL_X8: elemCount = perReg << 3;
      LMUL_F2: elemCount = perReg >> 1;
      LMUL_F4: elemCount = perReg >> 2;
      LMUL_F8: elemCount = perReg >> 3;
      default: elemCount = '0;
    endcase
  end

  assign outOfRange = {1'b0, idx} >= elemCount;

  // Group alignment
  always_comb begin
    unique case (lmul)
      LMUL_X2:   illegalGroup = base[0];
      LMUL_X4:   illegalGroup = |base[1:0];
      LMUL_X8:   illegalGroup = |base[2:0];
      LMUL_RSVD: illegalGroup = 1'b1;
      default:   illegalGroup = 1'b0;
    endcase
  end

  // Byte position inside the group, then split into register and lane
  assign byteLinear = {3'b000, idx} << sew;
  assign physReg    = REG_W'({{(LIN_W-REG_W){1'b0}}, base} + (byteLinear >> OFF_W));
  assign byteOff    = OFF_W'(byteLinear);

  always_comb begin
    unique case (sew)
      SEW_B8:  elemMask = VLEN_BYTES'(8'h01);
      SEW_B16: elemMask = VLEN_BYTES'(8'h03);
      SEW_B32: elemMask = VLEN_BYTES'(8'h0F);
      default: elemMask = VLEN_BYTES'(8'hFF);
    endcase
  end

  assign byteEn = elemMask << byteOff;

endmodule

// File: rtl/vrf_ctrl.sv
module vrf_ctrl
  import vrf_pkg::*;
#(
  parameter int  NUM_REGS   = 32,
  parameter int  VLEN_BYTES = 16,
  parameter int  IDX_W      = 8,
  parameter int  REG_W      = $clog2(NUM_REGS),
  parameter int  OFF_W      = $clog2(VLEN_BYTES),
  parameter type strobe_t   = logic
) (
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrBase,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [1:0]       wrSew,
  input  logic [2:0]       wrLmul,
  input  logic [REG_W-1:0] rdBase,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [1:0]       rdSew,
  input  logic [2:0]       rdLmul,
  output logic             wrOutOfRange,
  output logic             wrIllegalGroup,
  output logic             rdOutOfRange,
  output logic             rdIllegalGroup,
  output strobe_t          strobe
);

  localparam int NUM_PORTS = 2;  // 0: write, 1: read

  logic [REG_W-1:0]      portBase [NUM_PORTS];
  logic [IDX_W-1:0]      portIdx  [NUM_PORTS];
  sew_e                  portSew  [NUM_PORTS];
  logic [2:0]            portLmul [NUM_PORTS];
  logic [REG_W-1:0]      portReg  [NUM_PORTS];
  logic [OFF_W-1:0]      portOff  [NUM_PORTS];
  logic [VLEN_BYTES-1:0] portBen  [NUM_PORTS];
  logic [NUM_PORTS-1:0]  portOor;
  logic [NUM_PORTS-1:0]  portIll;

  assign portBase[0] = wrBase;
  assign portIdx[0]  = wrIdx;
  assign portSew[0]  = sew_e'(wrSew);
  assign portLmul[0] = wrLmul;
  assign portBase[1] = rdBase;
  assign portIdx[1]  = rdIdx;
  assign portSew[1]  = sew_e'(rdSew);
  assign portLmul[1] = rdLmul;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
    vrf_elem_map #(
      .NUM_REGS  (NUM_REGS),
      .VLEN_BYTES(VLEN_BYTES),
      .IDX_W     (IDX_W),
      .REG_W     (REG_W),
      .OFF_W     (OFF_W)
    ) u_map (
      .base        (portBase[p]),
      .idx         (portIdx[p]),
      .sew         (portSew[p]),
      .lmul        (portLmul[p]),
      .physReg     (portReg[p]),
      .byteOff     (portOff[p]),
      .byteEn      (portBen[p]),
      .outOfRange  (portOor[p]),
      .illegalGroup(portIll[p])
    );
  end

  assign wrOutOfRange   = portOor[0];
  assign wrIllegalGroup = portIll[0];
  assign rdOutOfRange   = portOor[1];
  assign rdIllegalGroup = portIll[1];

  always_comb begin
    strobe.wrCommit = wrEn & ~portOor[0] & ~portIll[0];
    strobe.wrReg    = portReg[0];
    strobe.wrOff    = portOff[0];
    strobe.wrByteEn = portBen[0];
    strobe.rdReg    = portReg[1];
    strobe.rdOff    = portOff[1];
    strobe.rdSew    = portSew[1];
    strobe.rdZero   = portOor[1] | portIll[1];
  end

endmodule

// File: rtl/vrf_datapath.sv
module vrf_datapath
  import vrf_pkg::*;
#(
  parameter int  NUM_REGS   = 32,
  parameter int  VLEN       = 128,
  parameter int  REG_W      = $clog2(NUM_REGS),
  parameter int  MASK_W     = $clog2(VLEN),
  parameter type strobe_t   = logic
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [ELEN-1:0]   wrData,
  input  logic [REG_W-1:0]  maskReg,
  input  logic [MASK_W-1:0] maskIdx,
  output logic [ELEN-1:0]   rdData,
  output logic              maskBit
);

  localparam int VLEN_BYTES = VLEN / 8;

  logic [VLEN-1:0]     regs [NUM_REGS];
  logic [NUM_REGS-1:0] rowWe;
  logic [VLEN-1:0]     laneData;
  logic [VLEN-1:0]     rdRow;
  logic [ELEN-1:0]     rdWindow;
  logic [ELEN-1:0]     widthMask;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    assign rowWe[r] = strobe.wrCommit && (strobe.wrReg == REG_W'(r));
  end

  assign laneData = VLEN'(wrData) << {strobe.wrOff, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        for (int b = 0; b < VLEN_BYTES; b++) begin
          if (rowWe[r] && strobe.wrByteEn[b]) regs[r][b*8 +: 8] <= laneData[b*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    unique case (strobe.rdSew)
      SEW_B8:  widthMask = ELEN'(8'hFF);
      SEW_B16: widthMask = ELEN'(16'hFFFF);
      SEW_B32: widthMask = ELEN'(32'hFFFF_FFFF);
      default: widthMask = '1;
    endcase
  end

  assign rdRow    = regs[strobe.rdReg];
  assign rdWindow = ELEN'(rdRow >> {strobe.rdOff, 3'b000});
  assign rdData   = strobe.rdZero ? '0 : (rdWindow & widthMask);
  assign maskBit  = regs[maskReg][maskIdx];

endmodule

// File: rtl/elem_vrf.sv
module elem_vrf
  import vrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int VLEN     = 128,
  parameter int REG_W    = $clog2(NUM_REGS),
  parameter int IDX_W    = $clog2(VLEN) + 1,
  parameter int MASK_W   = $clog2(VLEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrBase,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrSew,
  input  logic [2:0]        wrLmul,
  input  logic [ELEN-1:0]   wrData,
  output logic              wrOutOfRange,
  output logic              wrIllegalGroup,
  input  logic [REG_W-1:0]  rdBase,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [1:0]        rdSew,
  input  logic [2:0]        rdLmul,
  output logic [ELEN-1:0]   rdData,
  output logic              rdOutOfRange,
  output logic              rdIllegalGroup,
  input  logic [REG_W-1:0]  maskReg,
  input  logic [MASK_W-1:0] maskIdx,
  output logic              maskBit
);

  localparam int VLEN_BYTES = VLEN / 8;
  localparam int OFF_W      = $clog2(VLEN_BYTES);

  typedef struct packed {
    logic                  wrCommit;
    logic [REG_W-1:0]      wrReg;
    logic [OFF_W-1:0]      wrOff;
    logic [VLEN_BYTES-1:0] wrByteEn;
    logic [REG_W-1:0]      rdReg;
    logic [OFF_W-1:0]      rdOff;
    sew_e                  rdSew;
    logic                  rdZero;
  } strobe_t;

  strobe_t strobe;

  vrf_ctrl #(
    .NUM_REGS  (NUM_REGS),
    .VLEN_BYTES(VLEN_BYTES),
    .IDX_W     (IDX_W),
    .REG_W     (REG_W),
    .OFF_W     (OFF_W),
    .strobe_t  (strobe_t)
  ) u_ctrl (
    .wrEn          (wrEn),
    .wrBase        (wrBase),
    .wrIdx         (wrIdx),
    .wrSew         (wrSew),
    .wrLmul        (wrLmul),
    .rdBase        (rdBase),
    .rdIdx         (rdIdx),
    .rdSew         (rdSew),
    .rdLmul        (rdLmul),
    .wrOutOfRange  (wrOutOfRange),
    .wrIllegalGroup(wrIllegalGroup),
    .rdOutOfRange  (rdOutOfRange),
    .rdIllegalGroup(rdIllegalGroup),
    .strobe        (strobe)
  );

  vrf_datapath #(
    .NUM_REGS(NUM_REGS),
    .VLEN    (VLEN),
    .REG_W   (REG_W),
    .MASK_W  (MASK_W),
    .strobe_t(strobe_t)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrData (wrData),
    .maskReg(maskReg),
    .maskIdx(maskIdx),
    .rdData (rdData),
    .maskBit(maskBit)
  );

endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
  parameter int REG_W  = 5,
  parameter int IDX_W  = 8,
  parameter int MASK_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [REG_W-1:0]  wrBase,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [1:0]        wrSew,
  input logic [2:0]        wrLmul,
  input logic [63:0]       wrData,
  input logic              wrOutOfRange,
  input logic              wrIllegalGroup,
  input logic [REG_W-1:0]  rdBase,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [1:0]        rdSew,
  input logic [2:0]        rdLmul,
  input logic [63:0]       rdData,
  input logic              rdOutOfRange,
  input logic              rdIllegalGroup,
  input logic [REG_W-1:0]  maskReg,
  input logic [MASK_W-1:0] maskIdx,
  input logic              maskBit
);

  function automatic logic [63:0] keepBits(input logic [1:0] code);
    case (code)
      2'd0:    keepBits = 64'h0000_0000_0000_00FF;
      2'd1:    keepBits = 64'h0000_0000_0000_FFFF;
      2'd2:    keepBits = 64'h0000_0000_FFFF_FFFF;
      default: keepBits = '1;
    endcase
  endfunction

  // R5: read beyond the group gives zero
  assert_oor_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rdOutOfRange |-> rdData == 64'd0);

  // R6: illegal group read gives zero
  assert_bad_group_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    rdIllegalGroup |-> rdData == 64'd0);

  // R8: a committed write is visible on the next cycle at the same element
  assert_write_visible_next_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(wrEn && !wrOutOfRange && !wrIllegalGroup) && !$past(rst)
     && rdBase == $past(wrBase) && rdIdx == $past(wrIdx)
     && rdSew == $past(wrSew) && rdLmul == $past(wrLmul))
    |-> rdData == ($past(wrData) & keepBits(rdSew)));

  // R4: without a write, a steady mask address gives a steady mask bit
  assert_mask_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrEn) && $stable(maskReg) && $stable(maskIdx))
    |-> $stable(maskBit));

  // R9: the first cycle after reset sees cleared storage
  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdData == 64'd0 && !maskBit));

endmodule

bind elem_vrf vrf_checker #(
  .REG_W (REG_W),
  .IDX_W (IDX_W),
  .MASK_W(MASK_W)
) u_vrf_checker (
  .clk           (clk),
  .rst           (rst),
  .wrEn          (wrEn),
  .wrBase        (wrBase),
  .wrIdx         (wrIdx),
  .wrSew         (wrSew),
  .wrLmul        (wrLmul),
  .wrData        (wrData),
  .wrOutOfRange  (wrOutOfRange),
  .wrIllegalGroup(wrIllegalGroup),
  .rdBase        (rdBase),
  .rdIdx         (rdIdx),
  .rdSew         (rdSew),
  .rdLmul        (rdLmul),
  .rdData        (rdData),
  .rdOutOfRange  (rdOutOfRange),
  .rdIllegalGroup(rdIllegalGroup),
  .maskReg       (maskReg),
  .maskIdx       (maskIdx),
  .maskBit       (maskBit)
);

// File: tb/tb_elem_vrf.sv
`timescale 1ns/1ps
module tb_elem_vrf;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  wrBase = '0;
  logic [7:0]  wrIdx = '0;
  logic [1:0]  wrSew = '0;
  logic [2:0]  wrLmul = '0;
  logic [63:0] wrData = '0;
  logic        wrOutOfRange, wrIllegalGroup;
  logic [4:0]  rdBase = '0;
  logic [7:0]  rdIdx = '0;
  logic [1:0]  rdSew = '0;
  logic [2:0]  rdLmul = '0;
  logic [63:0] rdData;
  logic        rdOutOfRange, rdIllegalGroup;
  logic [4:0]  maskReg = '0;
  logic [6:0]  maskIdx = '0;
  logic        maskBit;

  int total = 0;
  int bad = 0;
  logic [7:0] model [0:511];

  always #2.5 clk = ~clk;

  elem_vrf dut (
    .clk(clk), .rst(rst),
    .wrEn(wrEn), .wrBase(wrBase), .wrIdx(wrIdx), .wrSew(wrSew), .wrLmul(wrLmul),
    .wrData(wrData), .wrOutOfRange(wrOutOfRange), .wrIllegalGroup(wrIllegalGroup),
    .rdBase(rdBase), .rdIdx(rdIdx), .rdSew(rdSew), .rdLmul(rdLmul),
    .rdData(rdData), .rdOutOfRange(rdOutOfRange), .rdIllegalGroup(rdIllegalGroup),
    .maskReg(maskReg), .maskIdx(maskIdx), .maskBit(maskBit)
  );

  // Group element count from width and multiplier codes
  function automatic int cntOf(int s, int l);
    int per = 16 >> s;
    case (l)
      0: return per;
      1: return per * 2;
      2: return per * 4;
      3: return per * 8;
      7: return per / 2;
      6: return per / 4;
      5: return per / 8;
      default: return 0;
    endcase
  endfunction

  function automatic bit illOf(int b, int l);
    case (l)
      1: return (b % 2) != 0;
      2: return (b % 4) != 0;
      3: return (b % 8) != 0;
      4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] modelRead(int b, int i, int s, int l);
    logic [63:0] d = '0;
    int eb = 1 << s;
    if (illOf(b, l) || i >= cntOf(s, l)) return '0;
    for (int k = 0; k < eb; k++) d[k*8 +: 8] = model[b*16 + i*eb + k];
    return d;
  endfunction

  task automatic modelWrite(int b, int i, int s, int l, logic [63:0] d);
    int eb = 1 << s;
    if (illOf(b, l) || i >= cntOf(s, l)) return;
    for (int k = 0; k < eb; k++) model[b*16 + i*eb + k] = d[k*8 +: 8];
  endtask

  task automatic expectVal(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(string tag, int b, int i, int s, int l, logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrBase = 5'(b); wrIdx = 8'(i); wrSew = 2'(s); wrLmul = 3'(l); wrData = d;
    #1;
    expectVal({tag, " wr range flag"}, 64'(wrOutOfRange), 64'(i >= cntOf(s, l)));
    expectVal({tag, " wr group flag"}, 64'(wrIllegalGroup), 64'(illOf(b, l)));
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(b, i, s, l, d);
  endtask

  task automatic checkRead(string tag, int b, int i, int s, int l);
    @(negedge clk);
    rdBase = 5'(b); rdIdx = 8'(i); rdSew = 2'(s); rdLmul = 3'(l);
    #1;
    expectVal({tag, " data"}, rdData, modelRead(b, i, s, l));
    expectVal({tag, " rd range flag"}, 64'(rdOutOfRange), 64'(i >= cntOf(s, l)));
    expectVal({tag, " rd group flag"}, 64'(rdIllegalGroup), 64'(illOf(b, l)));
  endtask

  task automatic readLit(string tag, int b, int i, int s, int l, logic [63:0] exp);
    @(negedge clk);
    rdBase = 5'(b); rdIdx = 8'(i); rdSew = 2'(s); rdLmul = 3'(l);
    #1;
    expectVal(tag, rdData, exp);
  endtask

  task automatic checkMask(string tag, int r, int i);
    logic [7:0] byteVal;
    @(negedge clk);
    maskReg = 5'(r); maskIdx = 7'(i);
    #1;
    byteVal = model[r*16 + i/8];
    expectVal(tag, 64'(maskBit), 64'(byteVal[i%8]));
  endtask

  task automatic pulseReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 512; k++) model[k] = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lmulCodes [8] = '{0, 1, 2, 3, 5, 6, 7, 4};
    void'($urandom(32'd20240611));
    for (int k = 0; k < 512; k++) model[k] = 8'h00;
    pulseReset();

    // R9: reset state
    for (int r = 0; r < 32; r += 7) checkRead("R9 reset", r, 1, 3, 0);
    checkMask("R9 reset mask", 31, 127);

    // R1: 32-bit packing, read back bytewise
    doWrite("R1", 4, 0, 2, 0, 64'h0000_0000_A3A2_A1A0);
    doWrite("R1", 4, 1, 2, 0, 64'hFFFF_FFFF_A7A6_A5A4);
    doWrite("R1", 4, 3, 2, 0, 64'h0000_0000_AFAE_ADAC);
    readLit("R1 byte5", 4, 5, 0, 0, 64'hA5);
    readLit("R1 byte15", 4, 15, 0, 0, 64'hAF);
    readLit("R1 half1", 4, 1, 1, 0, 64'hA3A2);
    readLit("R1 upper cleared", 4, 1, 2, 0, 64'hA7A6A5A4);

    // R2: group of two, element 5 lands in base+1 element 1
    doWrite("R2", 2, 5, 2, 1, 64'h0000_0000_CAFE_F00D);
    readLit("R2 next reg", 3, 1, 2, 0, 64'hCAFEF00D);
    checkRead("R2 group", 2, 5, 2, 1);
    doWrite("R2 x8 top", 24, 127, 0, 3, 64'h5A);
    readLit("R2 x8 last reg", 31, 15, 0, 0, 64'h5A);

    // R3: quarter group of bytes holds four elements in low bytes
    doWrite("R3", 7, 3, 0, 6, 64'h5C);
    readLit("R3 low bytes", 7, 3, 0, 0, 64'h5C);
    doWrite("R3 edge", 7, 4, 0, 6, 64'h77);
    readLit("R3 edge untouched", 7, 4, 0, 0, 64'h00);
    checkRead("R3 empty group", 7, 0, 3, 5);

    // R4: mask bit i of register, independent of width
    doWrite("R4", 9, 1, 0, 0, 64'h02);
    checkMask("R4 bit9", 9, 9);
    checkMask("R4 bit8", 9, 8);
    @(negedge clk); #1;
    expectVal("R4 bit9 literal", 64'(maskBit), 64'd0);
    maskIdx = 7'd9; #0.5;
    expectVal("R4 bit9 set", 64'(maskBit), 64'd1);

    // R5: out of range write and read
    doWrite("R5 setup", 10, 0, 3, 0, 64'h0123_4567_89AB_CDEF);
    doWrite("R5 oor", 10, 8, 1, 0, 64'hFFFF);
    readLit("R5 unchanged", 10, 0, 3, 0, 64'h0123_4567_89AB_CDEF);
    checkRead("R5 oor read", 10, 2, 3, 0);

    // R6: misaligned base and reserved code
    doWrite("R6 misaligned", 11, 0, 2, 1, 64'hDEAD_BEEF);
    readLit("R6 unchanged", 11, 0, 2, 0, 64'h0);
    doWrite("R6 reserved", 12, 0, 0, 4, 64'hEE);
    readLit("R6 reserved unchanged", 12, 0, 0, 0, 64'h0);
    checkRead("R6 misaligned read", 10, 0, 3, 2);

    // R7: byte enables keep neighbours
    doWrite("R7 setup", 20, 0, 3, 0, 64'h1122_3344_5566_7788);
    doWrite("R7", 20, 1, 1, 0, 64'hFFFF_FFFF_FFFF_ABCD);
    readLit("R7 neighbours", 20, 0, 3, 0, 64'h1122_3344_ABCD_7788);
    readLit("R7 other reg", 21, 0, 3, 0, 64'h0);

    // R8: same-cycle read returns old, new value next cycle
    doWrite("R8 setup", 13, 1, 2, 0, 64'h1111_1111);
    @(negedge clk);
    wrEn = 1'b1; wrBase = 5'd13; wrIdx = 8'd1; wrSew = 2'd2; wrLmul = 3'd0; wrData = 64'h2222_2222;
    rdBase = 5'd13; rdIdx = 8'd1; rdSew = 2'd2; rdLmul = 3'd0;
    #1;
    expectVal("R8 old value", rdData, 64'h1111_1111);
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(13, 1, 2, 0, 64'h2222_2222);
    #1;
    expectVal("R8 new value", rdData, 64'h2222_2222);

    // Random traffic across widths and multipliers (R1, R2, R3, R5, R6, R7)
    for (int n = 0; n < 400; n++) begin
      int s = $urandom_range(0, 3);
      int l = lmulCodes[$urandom_range(0, 7)];
      int b = $urandom_range(0, 31);
      int i = $urandom_range(0, cntOf(s, l) + 2);
      int rs = $urandom_range(0, 3);
      int rl = lmulCodes[$urandom_range(0, 7)];
      doWrite("R2 random", b, i, s, l, {$urandom, $urandom});
      if ($urandom_range(0, 1) == 1) checkRead("R1 random same", b, i, s, l);
      else checkRead("R7 random cross", b, $urandom_range(0, cntOf(rs, rl) + 1), rs, rl);
      checkMask("R4 random", $urandom_range(0, 31), $urandom_range(0, 127));
    end

    // R9: reset clears written data
    pulseReset();
    readLit("R9 cleared a", 20, 0, 3, 0, 64'h0);
    readLit("R9 cleared b", 4, 1, 2, 0, 64'h0);
    checkMask("R9 cleared mask", 9, 9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule